// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state of a bank of interrupt sources and turns that state into presentation requests for a downstream presenter. Each source is fixed at build time as either level-sensitive or message type. Each source holds a destination server, a priority and a small set of status flags. A priority of all ones (0xFF for the default 8-bit width) means the source is masked.

Requests leave through one registered valid/ready port. Each request carries the global interrupt number, the priority and the server. The presenter returns the outcome on three inputs. A reject tells the block that the interrupt bounced. An end-of-interrupt (EOI) tells it that a level interrupt has been serviced. A resend request starts a sweep that re-offers bounced or waiting sources. A configuration write port sets a source's server and priority.

Top module: `intsrc_ctrl`

## Requirements
- R1: After reset, pres_valid is 0, every priority is 0xFF (masked), every server is 0 and every status flag is clear. A message event that arrives straight after reset is therefore held as masked-pending and is not presented.
- R2: A presented source appears with pres_num = BASE + local index. Reject and EOI numbers are decoded by subtracting BASE. Numbers below BASE or at BASE+NSRC and above are ignored.
- R3: On a message source, each cycle with src_in high is one event. If the priority is 0xFF the event sets masked-pending and nothing is presented. Otherwise the source is queued for presentation.
- R4: The asserted flag of a level source follows its src_in pin. A rising pin queues the source when its priority is not 0xFF and sent is clear. Handing the source to the output sets sent. While sent is set, the source is not presented again, and a resend sweep does not bring it back.
- R5: A reject of a message source sets its rejected flag. A reject of a level source clears its sent flag. Neither presents anything by itself.
- R6: An EOI clears sent on a level source, so the next sweep re-presents it if the pin is still high. An EOI on a message source has no effect.
- R7: A resend request that arrives while no sweep runs starts a sweep. The sweep visits one source per cycle in ascending index and holds while pres_valid is high and pres_ready is low. A visited message source with rejected set clears the flag and is queued if its priority is not 0xFF. A visited level source is queued if it is asserted, not sent and not masked.
- R8: A configuration write stores a new server and priority. A message source with masked-pending set and a new priority other than 0xFF clears masked-pending and is queued. A level source that is asserted and not sent is queued when the new priority is not 0xFF.
- R9: When several sources are queued at once, the lowest index is loaded first. While pres_valid is high and pres_ready is low, pres_num, pres_prio and pres_server stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Level pin or per-cycle message event, one bit per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Local index of the source to configure |
| cfg_server | input | SRV_W | New destination server |
| cfg_prio | input | PRIO_W | New priority (all ones = masked) |
| pres_valid | output | 1 | Presentation request valid |
| pres_ready | input | 1 | Presenter accepts the request |
| pres_num | output | NUM_W | Global interrupt number |
| pres_prio | output | PRIO_W | Priority of the presented source |
| pres_server | output | SRV_W | Server of the presented source |
| rej_valid | input | 1 | Reject strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | EOI strobe |
| eoi_num | input | NUM_W | Global number being retired |
| resend_req | input | 1 | Start a resend sweep |

## Verification
The bench builds the block with eight sources, a base offset of 16 and the upper four sources set to level type. This puts both source kinds and both ends of the accepted number range within reach, and it lets reject and EOI numbers both below and above that range hit the filter. With eight sources a full sweep takes a handful of cycles, so many sweeps can overlap with held outputs, reconfiguration and bounces during a long random run. A behavioural model of the flags is compared with the outputs on every cycle.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;
  localparam int PRIO_W = 8;
  typedef logic [PRIO_W-1:0] prio_t;
  localparam prio_t PRIO_MASKED = '1;
endpackage

// File: rtl/intsrc_pick.sv
module intsrc_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0]                      elig,
  output logic                              any,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  // lowest eligible index wins
  always_comb begin
    any = |elig;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (elig[i]) idx = IW'(i);
  end
endmodule

// File: rtl/intsrc_sweep.sv
module intsrc_sweep #(
  parameter int N = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic                              stall,
  output logic                              busy,
  output logic                              step,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] ptr
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  assign step = busy && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        ptr  <= '0;
      end
    end else if (step) begin
      if (ptr == LAST) busy <= 1'b0;
      else             ptr  <= ptr + 1'b1;
    end
  end

  // R7: one source per cycle, frozen while the output is held
  a_r7_advance: assert property (@(posedge clk) disable iff (rst)
    busy && !stall && (ptr != LAST) |=> busy && (ptr == IW'($past(ptr) + 1'b1)));
  a_r7_stall: assert property (@(posedge clk) disable iff (rst)
    busy && stall |=> busy && $stable(ptr));
endmodule

// File: rtl/intsrc_ctrl.sv
module intsrc_ctrl
  import intsrc_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int BASE  = 16,
  parameter int NUM_W = 12,
  parameter int SRV_W = 4,
  parameter logic [NSRC-1:0] LEVEL_MASK = 8'hF0,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_in,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  output logic              pres_valid,
  input  logic              pres_ready,
  output logic [NUM_W-1:0]  pres_num,
  output logic [PRIO_W-1:0] pres_prio,
  output logic [SRV_W-1:0]  pres_server,
  input  logic              rej_valid,
  input  logic [NUM_W-1:0]  rej_num,
  input  logic              eoi_valid,
  input  logic [NUM_W-1:0]  eoi_num
  ,
  input  logic              resend_req
);
  localparam logic [NUM_W-1:0] BASE_N = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] CNT_N  = NUM_W'(NSRC);

  // per-source state
  prio_t            prio   [NSRC];
  logic [SRV_W-1:0] server [NSRC];
  logic [NSRC-1:0]  asserted, sent, rejected, mpend, queued;

  prio_t            n_prio   [NSRC];
  logic [SRV_W-1:0] n_server [NSRC];
  logic [NSRC-1:0]  n_asserted, n_sent, n_rejected, n_mpend, n_queued;

  // number decode
  logic [NUM_W-1:0] rej_off, eoi_off;
  logic             rej_hit, eoi_hit;
  assign rej_off = rej_num - BASE_N;
  assign eoi_off = eoi_num - BASE_N;
  assign rej_hit = rej_valid && (rej_num >= BASE_N) && (rej_off < CNT_N);
  assign eoi_hit = eoi_valid && (eoi_num >= BASE_N) && (eoi_off < CNT_N);

  // selection
  logic [NSRC-1:0] elig, issue;
  logic            any, load, fire;
  logic [IW-1:0]   pick_idx;

  always_comb
    for (int i = 0; i < NSRC; i++)
      elig[i] = LEVEL_MASK[i] ? (queued[i] && (prio[i] != PRIO_MASKED) && asserted[i] && !sent[i])
                              : queued[i];

  intsrc_pick #(.N(NSRC)) u_pick (.elig(elig), .any(any), .idx(pick_idx));

  assign load = !pres_valid || pres_ready;
  assign fire = load && any;

  always_comb
    for (int i = 0; i < NSRC; i++)
      issue[i] = fire && (pick_idx == IW'(i));

  // resend sweep
  logic          sw_busy, sw_step;
  logic [IW-1:0] sw_ptr;

  intsrc_sweep #(.N(NSRC)) u_sweep (
    .clk(clk), .rst(rst), .start(resend_req),
    .stall(pres_valid && !pres_ready),
    .busy(sw_busy), .step(sw_step), .ptr(sw_ptr)
  );

  // next state, applied in a fixed order: issue, reject, EOI, input, config, sweep
  always_comb begin
    n_asserted = asserted;
    n_sent     = sent;
    n_rejected = rejected;
    n_mpend    = mpend;
    n_queued   = queued;
    for (int i = 0; i < NSRC; i++) begin
      n_prio[i]   = prio[i];
      n_server[i] = server[i];

      if (issue[i]) begin
        n_queued[i] = 1'b0;
        if (LEVEL_MASK[i]) n_sent[i] = 1'b1;
      end
      if (rej_hit && (rej_off[IW-1:0] == IW'(i))) begin
        if (LEVEL_MASK[i]) n_sent[i]     = 1'b0;
        else               n_rejected[i] = 1'b1;
      end
      if (eoi_hit && (eoi_off[IW-1:0] == IW'(i)) && LEVEL_MASK[i])
        n_sent[i] = 1'b0;

      if (LEVEL_MASK[i]) begin
        n_asserted[i] = src_in[i];
        if (src_in[i] && !asserted[i] && (prio[i] != PRIO_MASKED) && !n_sent[i])
          n_queued[i] = 1'b1;
      end else if (src_in[i]) begin
        if (prio[i] == PRIO_MASKED) n_mpend[i]  = 1'b1;
        else                        n_queued[i] = 1'b1;
      end

      if (cfg_we && (cfg_idx == IW'(i))) begin
        n_prio[i]   = cfg_prio;
        n_server[i] = cfg_server;
        if (LEVEL_MASK[i]) begin
          if ((cfg_prio != PRIO_MASKED) && n_asserted[i] && !n_sent[i]) n_queued[i] = 1'b1;
        end else if (n_mpend[i] && (cfg_prio != PRIO_MASKED)) begin
          n_mpend[i]  = 1'b0;
          n_queued[i] = 1'b1;
        end
      end

      if (sw_step && (sw_ptr == IW'(i))) begin
        if (LEVEL_MASK[i]) begin
          if ((n_prio[i] != PRIO_MASKED) && n_asserted[i] && !n_sent[i]) n_queued[i] = 1'b1;
        end else if (n_rejected[i]) begin
          n_rejected[i] = 1'b0;
          if (n_prio[i] != PRIO_MASKED) n_queued[i] = 1'b1;
        end
      end

      // a level request that no longer meets its rule is dropped
      if (LEVEL_MASK[i] && !((n_prio[i] != PRIO_MASKED) && n_asserted[i] && !n_sent[i]))
        n_queued[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      asserted <= '0;
      sent     <= '0;
      rejected <= '0;
      mpend    <= '0;
      queued   <= '0;
      for (int i = 0; i < NSRC; i++) begin
        prio[i]   <= PRIO_MASKED;
        server[i] <= '0;
      end
    end else begin
      asserted <= n_asserted;
      sent     <= n_sent;
      rejected <= n_rejected;
      mpend    <= n_mpend;
      queued   <= n_queued;
      for (int i = 0; i < NSRC; i++) begin
        prio[i]   <= n_prio[i];
        server[i] <= n_server[i];
      end
    end
  end

  // registered presentation port
  always_ff @(posedge clk) begin
    if (rst) begin
      pres_valid  <= 1'b0;
      pres_num    <= '0;
      pres_prio   <= '0;
      pres_server <= '0;
    end else if (load) begin
      pres_valid <= any;
      if (any) begin
        pres_num    <= BASE_N + NUM_W'(pick_idx);
        pres_prio   <= prio[pick_idx];
        pres_server <= server[pick_idx];
      end
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !pres_valid);
  a_r2_num_range: assert property (@(posedge clk) disable iff (rst)
    pres_valid |-> (pres_num >= BASE_N) && (pres_num < BASE_N + CNT_N));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    pres_valid && !pres_ready |=> pres_valid && $stable(pres_num)
                                  && $stable(pres_prio) && $stable(pres_server));
  a_r9_single_issue: assert property (@(posedge clk) disable iff (rst) $onehot0(issue));
endmodule

// File: tb/intsrc_ctrl_tb.sv
module intsrc_ctrl_tb;
  localparam int N = 8;
  localparam int BASE = 16;
  localparam int NUM_W = 12;
  localparam int SRV_W = 4;
  localparam logic [N-1:0] LVL = 8'hF0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_in = '0;
  logic cfg_we = 0;
  logic [2:0] cfg_idx = '0;
  logic [SRV_W-1:0] cfg_server = '0;
  logic [7:0] cfg_prio = '0;
  logic pres_valid, pres_ready = 1'b0;
  logic [NUM_W-1:0] pres_num;
  logic [7:0] pres_prio;
  logic [SRV_W-1:0] pres_server;
  logic rej_valid = 0, eoi_valid = 0, resend_req = 0;
  logic [NUM_W-1:0] rej_num = '0, eoi_num = '0;

  always #4 clk = ~clk;

  intsrc_ctrl #(.NSRC(N), .BASE(BASE), .NUM_W(NUM_W), .SRV_W(SRV_W), .LEVEL_MASK(LVL)) u_dut (
    .clk(clk), .rst(rst), .src_in(src_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .pres_valid(pres_valid),
    .pres_ready(pres_ready), .pres_num(pres_num), .pres_prio(pres_prio),
    .pres_server(pres_server), .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_req(resend_req));

  int checks = 0, fails = 0;
  bit done = 0;

  // ---------------- behavioural reference ----------------
  bit m_as[N], m_sent[N], m_rej[N], m_mp[N], m_q[N];
  int m_prio[N], m_srv[N];
  bit m_valid;
  int m_num, m_po, m_so;
  bit sw_busy;
  int sw_ptr;

  function automatic bit lvl_ok(int i);
    return (m_prio[i] != 255) && m_as[i] && !m_sent[i];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_as[i] = 0; m_sent[i] = 0; m_rej[i] = 0; m_mp[i] = 0; m_q[i] = 0;
        m_prio[i] = 255; m_srv[i] = 0;
      end
      m_valid = 0; m_num = 0; m_po = 0; m_so = 0; sw_busy = 0; sw_ptr = 0;
    end else begin
      int pick;
      bit ld, stall, step, old_as;
      pick = -1;
      for (int i = N - 1; i >= 0; i--)
        if (LVL[i] ? (m_q[i] && lvl_ok(i)) : m_q[i]) pick = i;
      ld = !m_valid || pres_ready;
      stall = m_valid && !pres_ready;
      step = sw_busy && !stall;
      if (ld) begin
        m_valid = (pick >= 0);
        if (pick >= 0) begin m_num = BASE + pick; m_po = m_prio[pick]; m_so = m_srv[pick]; end
      end
      for (int i = 0; i < N; i++) begin
        old_as = m_as[i];
        if (ld && pick == i) begin m_q[i] = 0; if (LVL[i]) m_sent[i] = 1; end
        if (rej_valid && int'(rej_num) == BASE + i) begin
          if (LVL[i]) m_sent[i] = 0; else m_rej[i] = 1;
        end
        if (eoi_valid && int'(eoi_num) == BASE + i && LVL[i]) m_sent[i] = 0;
        if (LVL[i]) begin
          m_as[i] = src_in[i];
          if (src_in[i] && !old_as && m_prio[i] != 255 && !m_sent[i]) m_q[i] = 1;
        end else if (src_in[i]) begin
          if (m_prio[i] == 255) m_mp[i] = 1; else m_q[i] = 1;
        end
        if (cfg_we && int'(cfg_idx) == i) begin
          m_prio[i] = cfg_prio; m_srv[i] = cfg_server;
          if (LVL[i]) begin
            if (lvl_ok(i)) m_q[i] = 1;
          end else if (m_mp[i] && cfg_prio != 8'hFF) begin
            m_mp[i] = 0; m_q[i] = 1;
          end
        end
        if (step && sw_ptr == i) begin
          if (LVL[i]) begin
            if (lvl_ok(i)) m_q[i] = 1;
          end else if (m_rej[i]) begin
            m_rej[i] = 0;
            if (m_prio[i] != 255) m_q[i] = 1;
          end
        end
        if (LVL[i] && !lvl_ok(i)) m_q[i] = 0;
      end
      if (!sw_busy) begin
        if (resend_req) begin sw_busy = 1; sw_ptr = 0; end
      end else if (step) begin
        if (sw_ptr == N - 1) sw_busy = 0; else sw_ptr++;
      end
    end
  end

  // R9 (and every other requirement through the model): compare each cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (pres_valid !== m_valid ||
          (m_valid && (int'(pres_num) != m_num || int'(pres_prio) != m_po || int'(pres_server) != m_so))) begin
        fails++;
        $display("FAIL R9 model: valid/num/prio/srv %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                 pres_valid, pres_num, pres_prio, pres_server, m_valid, m_num, m_po, m_so);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(int idx, int p, int s);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_prio = 8'(p); cfg_server = SRV_W'(s);
    tick(); cfg_we = 0;
  endtask

  task automatic pulse_src(logic [N-1:0] m);
    src_in = src_in | m; tick(); src_in = src_in & ~m;
  endtask

  task automatic accept();
    pres_ready = 1; tick(); pres_ready = 0;
  endtask

  task automatic resend_wait();
    resend_req = 1; tick(); resend_req = 0;
    for (int k = 0; k < 12; k++) if (!pres_valid) tick();
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    chk("R1 idle after reset", pres_valid, 0);

    // R3: message event while masked is held back
    pulse_src(8'h02); tick();
    chk("R3 masked event not presented", pres_valid, 0);

    // R8: configuring a priority releases masked-pending
    cfg(1, 3, 5); tick();
    chk("R8 release valid", pres_valid, 1);
    chk("R2 number base+1", pres_num, 17);
    chk("R8 prio", pres_prio, 3);
    chk("R8 server", pres_server, 5);

    // R9: hold and lowest-index order
    cfg(2, 4, 1); cfg(0, 2, 7);
    pulse_src(8'h05); tick();
    chk("R9 held while not ready", pres_num, 17);
    pres_ready = 1; tick();
    chk("R9 lowest index first", pres_num, 16);
    tick();
    chk("R9 next index", pres_num, 18);
    pres_ready = 0; tick();
    chk("R9 stays", pres_num, 18);
    accept();
    chk("R9 drained", pres_valid, 0);

    // R5 / R7: reject of a message, then resend
    rej_valid = 1; rej_num = 18; tick(); rej_valid = 0; tick();
    chk("R5 reject alone presents nothing", pres_valid, 0);
    resend_wait();
    chk("R7 resend re-presents", pres_valid, 1);
    chk("R7 resend number", pres_num, 18);
    accept(); repeat (8) tick();

    // R4: level source
    cfg(5, 6, 2);
    src_in[5] = 1; tick(); tick();
    chk("R4 level presented", pres_num, 21);
    chk("R4 level prio", pres_prio, 6);
    accept();
    resend_wait();
    chk("R4 sent blocks resend", pres_valid, 0);

    // R6: EOI on level, and on message
    eoi_valid = 1; eoi_num = 21; tick(); eoi_valid = 0;
    resend_wait();
    chk("R6 EOI then resend", pres_num, 21);
    accept();
    eoi_valid = 1; eoi_num = 17; tick(); eoi_valid = 0;
    resend_wait();
    chk("R6 message EOI no effect", pres_valid, 0);

    // R2: out-of-range reject ignored
    rej_valid = 1; rej_num = 29; tick(); rej_num = 5; tick(); rej_valid = 0;
    resend_wait();
    chk("R2 out-of-range reject ignored", pres_valid, 0);

    // R5: reject of a level clears sent
    rej_valid = 1; rej_num = 21; tick(); rej_valid = 0;
    resend_wait();
    chk("R5 level reject re-offered", pres_num, 21);
    accept();
    src_in[5] = 0; tick();

    // random phase, checked by the model every cycle
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] s;
      s = src_in;
      for (int i = 0; i < N; i++) begin
        if (LVL[i]) begin if ($urandom_range(0, 15) == 0) s[i] = ~s[i]; end
        else s[i] = ($urandom_range(0, 9) == 0);
      end
      src_in = s;
      cfg_we = ($urandom_range(0, 7) == 0);
      cfg_idx = 3'($urandom_range(0, 7));
      cfg_prio = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 254));
      cfg_server = SRV_W'($urandom_range(0, 15));
      rej_valid = ($urandom_range(0, 9) == 0);
      rej_num = NUM_W'($urandom_range(12, 27));
      eoi_valid = ($urandom_range(0, 9) == 0);
      eoi_num = NUM_W'($urandom_range(12, 27));
      resend_req = ($urandom_range(0, 11) == 0);
      pres_ready = ($urandom_range(0, 9) < 7);
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule